// File: doc/BRIEF.md
# Bit-Serial Hypercube Cut-Through Router

This block is the switching element of one node in a binary hypercube of `DIMS` dimensions. Each dimension has one serial input link and one serial output link. The local node has its own injection input and ejection output. Every link carries one bit per cycle with a valid/ready handshake. Messages come in as a stream of bits, least significant first. The router learns the destination from the first bits of the envelope, which lets it pick an output port before the rest of the message arrives. It then passes the bits through by cut-through, so the head of a message leaves while its tail is still coming in.

Routing is dimension-ordered. The router XORs the destination with its own node address and sends the message out on the lowest dimension where the two differ. If there is no difference, the message goes to the ejection port. An output port stays with one input from the grant until the last bit of that message has left. Inputs that contend for the same output are served in round-robin order. An input whose output is taken keeps accepting bits into a small FIFO until the FIFO is full. It then drops its ready, which stalls the upstream link without losing any bits. Each input link and each output link runs independently of the others. A message can therefore arrive on a dimension while another message leaves on that same dimension.

Top module: `hcube_router`

## Requirements
- R1: After reset every output's valid is low and every input's ready is high.
- R2: A message whose destination field equals `nodeId` leaves only on the ejection port (port index `DIMS`), with every bit unchanged.
- R3: A message whose destination differs from `nodeId` leaves only on link output d, where d is the lowest bit position at which destination XOR `nodeId` is 1. Link port index d serves dimension d.
- R4: A message is a 36-bit header followed by a payload, sent least significant bit first. Header bits [DIMS-1:0] hold the destination. Header bits [35:20] hold the payload length in bits. The bits between these two fields are reserved. The message is 36 + length bits long and is forwarded bit for bit in the same order.
- R5: Forwarding is cut-through. The chosen output starts sending before the last bit of the message has been accepted at the input.
- R6: Once an output is granted to an input, it carries only that input's message until its final bit has left. Messages from different inputs never interleave on one output.
- R7: Inputs that contend for one free output are granted round-robin. The search starts at the input after the one granted last on that output, and input 0 is searched first after reset.
- R8: While its output is taken or stalled, an input buffers up to `FIFO_DEPTH` bits and then holds its ready low. No accepted bit is lost or reordered.
- R9: An input link and the output link of the same dimension carry two different messages in the same cycles.
- R10: After accepting the final bit of a message, an input holds its ready low until that message has fully left the router. It then accepts the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nodeId | input | DIMS | Address of this node |
| inData | input | DIMS+1 | Serial data bit per input; index d is dimension d, index DIMS is injection |
| inValid | input | DIMS+1 | Input bit is present |
| inReady | output | DIMS+1 | Input can take a bit this cycle |
| outData | output | DIMS+1 | Serial data bit per output; index d is dimension d, index DIMS is ejection |
| outValid | output | DIMS+1 | Output bit is present |
| outReady | input | DIMS+1 | Downstream takes the output bit this cycle |

## Verification
The assertions watch, on every cycle, the invariants that hold whatever the traffic. No FIFO is ever filled past its depth or popped while empty. A granted output keeps the same owner until release. Every output's owner still requests that same output. Only the bench's scenarios can show the behaviours that depend on message content and order. These are the bit-exact delivery of messages to the correct port for each dimension and for ejection, and the grant order under contention. The bench also shows that the output starts before the tail has arrived, that a stalled output propagates back as a stall, and that an input stays closed between back-to-back messages.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  // Envelope layout: fixed-length header, length field at its top end.
  localparam int HDR_BITS = 36;
  localparam int LEN_W    = 16;
  localparam int LEN_LSB  = HDR_BITS - LEN_W;

  // Per-input strobes issued by the control to the datapath.
  typedef struct packed {
    logic pop;    // remove head bit from the input FIFO
    logic clear;  // message fully forwarded: rearm header decode
  } portStrobe_t;
endpackage

// File: rtl/hcr_datapath.sv
module hcr_datapath
  import hcr_pkg::*;
#(
  parameter int DIMS       = 4,
  parameter int FIFO_DEPTH = 8,   // power of two, at least DIMS+2
  localparam int NP = DIMS + 1,
  localparam int PW = $clog2(NP)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DIMS-1:0]         nodeId,
  input  logic [NP-1:0]           inData,
  input  logic [NP-1:0]           inValid,
  output logic [NP-1:0]           inReady,
  input  portStrobe_t [NP-1:0]    strobe,
  output logic [NP-1:0]           reqValid,
  output logic [NP-1:0][PW-1:0]   reqPort,
  output logic [NP-1:0]           tailIn,
  output logic [NP-1:0]           empty,
  output logic [NP-1:0]           headBit
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int MW = LEN_W + 1;

  for (genvar i = 0; i < NP; i++) begin : g_in
    logic [FIFO_DEPTH-1:0] mem;
    logic [AW-1:0]         wrPtr, rdPtr;
    logic [CW-1:0]         fill;
    logic [MW-1:0]         bitCnt;
    logic [DIMS-1:0]       destReg, diff;
    logic [LEN_W-1:0]      lenReg, lenNow;
    logic                  tailSeen, destKnown, push, lastBit;
    logic [PW-1:0]         route;

    assign inReady[i] = (fill != CW'(FIFO_DEPTH)) && !tailSeen;
    assign push       = inValid[i] && inReady[i];

    // Length is complete only with the final header bit; splice it in.
    always_comb begin
      lenNow  = (bitCnt == MW'(HDR_BITS - 1)) ? {inData[i], lenReg[LEN_W-1:1]} : lenReg;
      lastBit = (bitCnt >= MW'(HDR_BITS - 1)) &&
                (bitCnt == MW'(HDR_BITS - 1) + MW'(lenNow));
    end

    // Dimension-order decision: lowest differing address bit, else eject.
    always_comb begin
      diff  = destReg ^ nodeId;
      route = PW'(DIMS);
      for (int d = DIMS - 1; d >= 0; d--)
        if (diff[d]) route = PW'(d);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mem <= '0; wrPtr <= '0; rdPtr <= '0; fill <= '0;
        bitCnt <= '0; destReg <= '0; lenReg <= '0;
        tailSeen <= 1'b0; destKnown <= 1'b0;
      end else begin
        if (push) begin
          mem[wrPtr] <= inData[i];
          wrPtr      <= wrPtr + 1'b1;
          bitCnt     <= bitCnt + 1'b1;
          if (bitCnt < MW'(DIMS)) destReg <= {inData[i], destReg[DIMS-1:1]};
          if (bitCnt == MW'(DIMS - 1)) destKnown <= 1'b1;
          if (bitCnt >= MW'(LEN_LSB) && bitCnt < MW'(HDR_BITS))
            lenReg <= {inData[i], lenReg[LEN_W-1:1]};
          if (lastBit) tailSeen <= 1'b1;
        end
        if (strobe[i].pop) rdPtr <= rdPtr + 1'b1;
        fill <= fill + CW'(push) - CW'(strobe[i].pop);
        if (strobe[i].clear) begin
          bitCnt <= '0; tailSeen <= 1'b0; destKnown <= 1'b0;
        end
      end
    end

    assign reqValid[i] = destKnown;
    assign reqPort[i]  = route;
    assign tailIn[i]   = tailSeen;
    assign empty[i]    = (fill == '0);
    assign headBit[i]  = mem[rdPtr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      fill <= CW'(FIFO_DEPTH)); // R8
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].pop |-> (fill != '0)); // R8
  end
endmodule

// File: rtl/hcr_control.sv
module hcr_control
  import hcr_pkg::*;
#(
  parameter int DIMS = 4,
  localparam int NP = DIMS + 1,
  localparam int PW = $clog2(NP)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NP-1:0]         reqValid,
  input  logic [NP-1:0][PW-1:0] reqPort,
  input  logic [NP-1:0]         tailIn,
  input  logic [NP-1:0]         empty,
  input  logic [NP-1:0]         headBit,
  input  logic [NP-1:0]         outReady,
  output logic [NP-1:0]         outValid,
  output logic [NP-1:0]         outData,
  output portStrobe_t [NP-1:0]  strobe
);
  logic [NP-1:0]         busy, granted, winValid, relOut;
  logic [NP-1:0][PW-1:0] owner, rrPtr, winner;

  always_comb begin
    granted = '0;
    for (int o = 0; o < NP; o++)
      if (busy[o]) granted[owner[o]] = 1'b1;
  end

  // Round-robin search per free output, starting after its last grant.
  always_comb begin
    int idx;
    winValid = '0;
    winner   = '0;
    for (int o = 0; o < NP; o++)
      for (int k = 0; k < NP; k++) begin
        idx = (int'(rrPtr[o]) + 1 + k) % NP;
        if (!busy[o] && !winValid[o] && reqValid[idx] && !granted[idx] &&
            reqPort[idx] == PW'(o)) begin
          winValid[o] = 1'b1;
          winner[o]   = PW'(idx);
        end
      end
  end

  always_comb begin
    strobe   = '0;
    outValid = '0;
    outData  = '0;
    relOut   = '0;
    for (int o = 0; o < NP; o++)
      if (busy[o]) begin
        outValid[o] = !empty[owner[o]];
        outData[o]  = headBit[owner[o]];
        relOut[o]   = tailIn[owner[o]] && empty[owner[o]];
        if (outReady[o] && !empty[owner[o]]) strobe[owner[o]].pop = 1'b1;
        if (relOut[o]) strobe[owner[o]].clear = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= '0;
      owner <= '0;
      for (int o = 0; o < NP; o++) rrPtr[o] <= PW'(NP - 1);
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (busy[o] && relOut[o]) busy[o] <= 1'b0;
        else if (winValid[o]) begin
          busy[o]  <= 1'b1;
          owner[o] <= winner[o];
          rrPtr[o] <= winner[o];
        end
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_chk
    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rstN)
      busy[o] && !relOut[o] |=> busy[o] && owner[o] == $past(owner[o])); // R6
    AST_ROUTE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      busy[o] |-> reqValid[owner[o]] && reqPort[owner[o]] == PW'(o)); // R3
  end
endmodule

// File: rtl/hcube_router.sv
module hcube_router
  import hcr_pkg::*;
#(
  parameter int DIMS       = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DIMS-1:0] nodeId,
  input  logic [DIMS:0]   inData,
  input  logic [DIMS:0]   inValid,
  output logic [DIMS:0]   inReady,
  output logic [DIMS:0]   outData,
  output logic [DIMS:0]   outValid,
  input  logic [DIMS:0]   outReady
);
  localparam int NP = DIMS + 1;
  localparam int PW = $clog2(NP);

  portStrobe_t [NP-1:0]  strobe;
  logic [NP-1:0]         reqValid, tailIn, empty, headBit;
  logic [NP-1:0][PW-1:0] reqPort;

  hcr_datapath #(.DIMS(DIMS), .FIFO_DEPTH(FIFO_DEPTH)) uDatapath (
    .clk(clk), .rstN(rstN), .nodeId(nodeId),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .strobe(strobe), .reqValid(reqValid), .reqPort(reqPort),
    .tailIn(tailIn), .empty(empty), .headBit(headBit)
  );

  hcr_control #(.DIMS(DIMS)) uControl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqPort(reqPort), .tailIn(tailIn),
    .empty(empty), .headBit(headBit), .outReady(outReady),
    .outValid(outValid), .outData(outData), .strobe(strobe)
  );
endmodule

// File: tb/hcube_router_test.sv
`timescale 1ns/1ps
module hcube_router_test;
  localparam int DIMS = 4;
  localparam int NP   = DIMS + 1;
  localparam int EJ   = DIMS;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic [DIMS-1:0] nodeId = 4'b0101;
  logic [NP-1:0] inData = '0, inValid = '0, outReady = '1;
  logic [NP-1:0] inReady, outData, outValid;

  int checks = 0, errors = 0, cyc = 0;
  logic [511:0] rxMem [NP];
  int rxCnt [NP];
  int firstCyc [NP];
  int sentBits [NP];
  bit bothActive;

  hcube_router #(.DIMS(DIMS), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .nodeId(nodeId),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  always #2 clk = ~clk;

  // Output monitor, sampled after the falling edge.
  always begin
    @(negedge clk); #1;
    cyc++;
    if (outValid[0] && outValid[EJ]) bothActive = 1'b1;
    for (int o = 0; o < NP; o++)
      if (outValid[o] && outReady[o]) begin
        if (rxCnt[o] == 0) firstCyc[o] = cyc;
        rxMem[o][rxCnt[o]] = outData[o];
        rxCnt[o]++;
      end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkMsg(logic [DIMS-1:0] dest, int len, logic [63:0] pay);
    logic [63:0] m = '0;
    m[DIMS-1:0] = dest;
    m[35:20] = 16'(len);
    for (int k = 0; k < len; k++) m[36+k] = pay[k];
    return m;
  endfunction

  function automatic logic [63:0] getRx(int o, int start, int n);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) r[k] = rxMem[o][start+k];
    return r;
  endfunction

  task automatic clearRx();
    for (int o = 0; o < NP; o++) begin rxCnt[o] = 0; firstCyc[o] = -1; end
    bothActive = 1'b0;
  endtask

  task automatic sendMsg(int p, logic [63:0] m, int nbits);
    sentBits[p] = 0;
    for (int k = 0; k < nbits; k++) begin
      inValid[p] = 1'b1;
      inData[p]  = m[k];
      while (!inReady[p]) @(negedge clk);
      @(negedge clk);
      sentBits[p]++;
    end
    inValid[p] = 1'b0;
    inData[p]  = 1'b0;
  endtask

  task automatic testReset();
    check("R1 outValid after reset", 64'(outValid), 64'h0);
    check("R1 inReady after reset", 64'(inReady), 64'h1f);
  endtask

  task automatic testEject();
    logic [63:0] m = mkMsg(nodeId, 16, 64'hbeef);
    int doneCyc;
    clearRx();
    sendMsg(EJ, m, 52);
    doneCyc = cyc;
    repeat (15) @(negedge clk);
    check("R2 eject bit count", 64'(rxCnt[EJ]), 64'd52);
    check("R4 eject bits unchanged", getRx(EJ, 0, 52), m);
    check("R2 no link output used", 64'(rxCnt[0] + rxCnt[1] + rxCnt[2] + rxCnt[3]), 64'd0);
    check("R5 output began before tail accepted", 64'(firstCyc[EJ] < doneCyc), 64'd1);
  endtask

  task automatic testDims();
    logic [DIMS-1:0] flip [DIMS] = '{4'b1001, 4'b1010, 4'b1100, 4'b1000};
    for (int d = 0; d < DIMS; d++) begin
      logic [63:0] m = mkMsg(nodeId ^ flip[d], 8, 64'(8'h5a + d));
      clearRx();
      sendMsg(EJ, m, 44);
      repeat (12) @(negedge clk);
      check($sformatf("R3 dim %0d bits", d), getRx(d, 0, 44), m);
      check($sformatf("R3 dim %0d only that port", d),
            64'(rxCnt[0] + rxCnt[1] + rxCnt[2] + rxCnt[3] + rxCnt[EJ]), 64'd44);
    end
  endtask

  task automatic testContend();
    logic [63:0] mA = mkMsg(nodeId, 12, 64'h0a1);
    logic [63:0] mB = mkMsg(nodeId, 12, 64'h0b2);
    logic [63:0] mC = mkMsg(nodeId, 12, 64'h0c3);
    logic [63:0] mD = mkMsg(nodeId, 12, 64'h0d4);
    clearRx();
    fork sendMsg(1, mA, 48); sendMsg(2, mB, 48); join
    repeat (60) @(negedge clk);
    check("R7 input 1 served first", getRx(EJ, 0, 48), mA);
    check("R6 second message whole, not interleaved", getRx(EJ, 48, 48), mB);
    clearRx();
    fork sendMsg(1, mC, 48); sendMsg(3, mD, 48); join
    repeat (60) @(negedge clk);
    check("R7 pointer moved: input 3 first", getRx(EJ, 0, 48), mD);
    check("R6 then input 1 whole", getRx(EJ, 48, 48), mC);
  endtask

  task automatic testBackpressure();
    logic [63:0] m = mkMsg(nodeId, 8, 64'h96);
    clearRx();
    outReady[EJ] = 1'b0;
    fork
      sendMsg(EJ, m, 44);
      begin
        repeat (40) @(negedge clk);
        check("R8 input stalled", 64'(inReady[EJ]), 64'd0);
        check("R8 buffered bits", 64'(sentBits[EJ]), 64'(DEPTH));
        check("R8 output presenting", 64'(outValid[EJ]), 64'd1);
        check("R8 nothing taken", 64'(rxCnt[EJ]), 64'd0);
        outReady[EJ] = 1'b1;
      end
    join
    repeat (15) @(negedge clk);
    check("R8 message intact after stall", getRx(EJ, 0, 44), m);
  endtask

  task automatic testParallel();
    logic [63:0] mIn  = mkMsg(nodeId, 16, 64'h1234);
    logic [63:0] mOut = mkMsg(nodeId ^ 4'b0001, 16, 64'h4321);
    clearRx();
    fork sendMsg(0, mIn, 52); sendMsg(EJ, mOut, 52); join
    repeat (15) @(negedge clk);
    check("R9 dim0 input reached eject", getRx(EJ, 0, 52), mIn);
    check("R9 dim0 output carried other message", getRx(0, 0, 52), mOut);
    check("R9 both active together", 64'(bothActive), 64'd1);
  endtask

  task automatic testBackToBack();
    logic [63:0] m1 = mkMsg(nodeId ^ 4'b0010, 4, 64'h9);
    logic [63:0] m2 = mkMsg(nodeId, 4, 64'h6);
    clearRx();
    sendMsg(EJ, m1, 40);
    check("R10 ready low after tail", 64'(inReady[EJ]), 64'd0);
    sendMsg(EJ, m2, 40);
    repeat (15) @(negedge clk);
    check("R10 first message on dim1", getRx(1, 0, 40), m1);
    check("R10 next message accepted and ejected", getRx(EJ, 0, 40), m2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearRx();
    for (int p = 0; p < NP; p++) sentBits[p] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEject();
    testDims();
    testContend();
    testBackpressure();
    testParallel();
    testBackToBack();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule